// File: doc/BRIEF.md
# Precision Time Protocol System Clock Counter

This block holds a network timekeeping clock as a 32-bit seconds count and a 32-bit nanoseconds count. The clock steps forward on pulses of a reference-clock enable, `ref_tick`. Each step adds a programmable increment of whole nanoseconds. In coarse mode every enabled tick advances the time. In fine mode a 32-bit phase accumulator adds a frequency-trim addend on every enabled tick, and the time advances only when that accumulator carries out. The nanoseconds count wraps into the seconds count at one of two limits. Decimal mode wraps at 1,000,000,000. Binary mode wraps at 2^31.

Software drives the block through a small word-addressed register bus. It can load the time outright, add or subtract a signed offset, and move a newly written addend into use. Each of these three operations is started by a command bit in the control word. The bit stays set while the operation waits for the next reference tick and clears itself when the operation runs, so software polls it for zero. The live time is presented on two output ports, and it can also be read over the bus.

Top module: `ptp_sys_clock`

## Requirements
- R1: After reset, every register reads 0, the time outputs are 0 and the accumulator is 0.
- R2: The increment register holds the whole-nanosecond step in bits [7:0] and a sub-nanosecond field in bits [15:8]. The sub-nanosecond field is stored and read back but does not affect counting. With the control enable bit (bit 0) set and the fine bit (bit 1) clear, each cycle with `ref_tick` high adds the step to the nanoseconds. A cycle without `ref_tick` leaves the time unchanged.
- R3: With control bit 9 set (decimal mode), if nanoseconds plus step reaches 1,000,000,000, the nanoseconds become that sum minus 1,000,000,000 and the seconds increase by one, modulo 2^32.
- R4: With control bit 9 clear (binary mode), the same wrap happens at 2^31.
- R5: With bits 0 and 1 set, each tick adds the active addend to a 32-bit accumulator. The time steps on that tick only if the addition carries out of bit 31.
- R6: Writing 1 to control bit 5 copies the addend register (address 2) into the active addend (read at address 7) on the next tick. Bit 5 reads 1 until that tick and 0 afterwards.
- R7: Writing 1 to control bit 2 loads the seconds word (address 3) and bits [30:0] of the nanoseconds word (address 4) into the time on the next tick, and the bit then clears. If bits 2 and 3 are both pending, the load runs on one tick and the offset runs on the following tick.
- R8: Writing 1 to control bit 3 applies an offset on the next tick, and the bit then clears. With bit 31 of the nanoseconds word clear, the seconds word and field F = bits [30:0] are added to the time. A nanoseconds sum at or above the active limit wraps and carries one second.
- R9: With bit 31 of the nanoseconds word set, the offset subtracts. The seconds word holds the negated seconds, and F holds the limit minus the nanoseconds. The result nanoseconds are ns+F-limit when that is not negative. Otherwise they are ns+F, and one extra second is borrowed.
- R10: While a command bit is pending, control writes leave it unchanged, including writes of 0.
- R11: With control bit 0 clear, ticks move neither the time nor the accumulator, but commands still run.
- R12: The register addresses are: 0 control, 1 increment, 2 addend, 3 seconds word, 4 nanoseconds word, 5 live seconds, 6 live nanoseconds, 7 active addend. Control reads back bits 0, 1 and 9 as written and bits 2, 3 and 5 as pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference-clock enable, one cycle per reference period |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sec_o | output | 32 | Live seconds |
| ns_o | output | 32 | Live nanoseconds |

## Verification
The bench targets these corner cases:

- A wrap where nanoseconds plus step lands exactly on the limit or just past it, in both modes. A design with an off-by-one compare would show 1,000,000,000 or 2^31 on `ns_o` for a cycle.
- A seconds wrap from all ones to zero.
- Subtraction offsets both with and without a borrow. A design that carries instead of borrowing ends two seconds off.
- A command written again while still pending, and a load and an offset queued together. A design that let a write cancel a pending command, or ran both commands on one tick, would lose an operation.
- An addend load that must not reach the accumulator before its tick.
- Ticks arriving while the counter is disabled.

// File: rtl/ptp_clk_pkg.sv
package ptp_clk_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    // control word bit positions (software decodes these)
    localparam int CB_EN    = 0;
    localparam int CB_FINE  = 1;
    localparam int CB_INIT  = 2;
    localparam int CB_UPD   = 3;
    localparam int CB_ADDLD = 5;
    localparam int CB_DEC   = 9;

    localparam logic [DATA_W:0] DEC_LIMIT = 33'd1_000_000_000;
    localparam logic [DATA_W:0] BIN_LIMIT = 33'h0_8000_0000;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_INCR   = 3'd1,
        RA_ADDEND = 3'd2,
        RA_USEC   = 3'd3,
        RA_UWORD  = 3'd4,
        RA_SEC    = 3'd5,
        RA_NSEC   = 3'd6,
        RA_ADDACT = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic en;
        logic fine;
        logic dec;
    } mode_t;

endpackage

// File: rtl/ptp_clk_regs.sv
module ptp_clk_regs
    import ptp_clk_pkg::*;
#(
    parameter int INC_W   = 8,
    parameter int SUBNS_W = 8,
    parameter int ACC_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_tick,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output mode_t              mode_o,
    output logic [INC_W-1:0]   inc_o,
    output logic [SUBNS_W-1:0] subns_o,
    output logic [ACC_W-1:0]   add_shadow_o,
    output logic [ACC_W-1:0]   add_active_o,
    output logic [DATA_W-1:0]  usec_o,
    output logic [DATA_W-1:0]  uword_o,
    output logic               pend_init_o,
    output logic               pend_upd_o,
    output logic               pend_add_o,
    output logic               exec_init_o,
    output logic               exec_upd_o
);

    localparam int SUBNS_LSB = INC_W;

    typedef struct packed {
        mode_t               mode;
        logic [INC_W-1:0]    inc;
        logic [SUBNS_W-1:0]  subns;
        logic [ACC_W-1:0]    add_sh;
        logic [ACC_W-1:0]    add_act;
        logic [DATA_W-1:0]   usec;
        logic [DATA_W-1:0]   uword;
        logic                p_init;
        logic                p_upd;
        logic                p_add;
    } regs_t;

    regs_t q, d;
    logic  wr_ctrl;
    logic  ex_init, ex_upd, ex_add;

    assign wr_ctrl = bus_we && (bus_addr == RA_CTRL);
    assign ex_init = ref_tick && q.p_init;
    assign ex_upd  = ref_tick && q.p_upd && !q.p_init;
    assign ex_add  = ref_tick && q.p_add;

    always_comb begin
        d = q;
        // command bits: a pending bit only clears on execution
        d.p_init = q.p_init ? !ex_init : (wr_ctrl && bus_wdata[CB_INIT]);
        d.p_upd  = q.p_upd  ? !ex_upd  : (wr_ctrl && bus_wdata[CB_UPD]);
        d.p_add  = q.p_add  ? !ex_add  : (wr_ctrl && bus_wdata[CB_ADDLD]);
        if (ex_add) begin
            d.add_act = q.add_sh;
        end
        if (bus_we) begin
            case (bus_addr)
                RA_CTRL: begin
                    d.mode.en   = bus_wdata[CB_EN];
                    d.mode.fine = bus_wdata[CB_FINE];
                    d.mode.dec  = bus_wdata[CB_DEC];
                end
                RA_INCR: begin
                    d.inc   = bus_wdata[INC_W-1:0];
                    d.subns = bus_wdata[SUBNS_LSB +: SUBNS_W];
                end
                RA_ADDEND: d.add_sh = bus_wdata[ACC_W-1:0];
                RA_USEC:   d.usec   = bus_wdata;
                RA_UWORD:  d.uword  = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mode_o       = q.mode;
    assign inc_o        = q.inc;
    assign subns_o      = q.subns;
    assign add_shadow_o = q.add_sh;
    assign add_active_o = q.add_act;
    assign usec_o       = q.usec;
    assign uword_o      = q.uword;
    assign pend_init_o  = q.p_init;
    assign pend_upd_o   = q.p_upd;
    assign pend_add_o   = q.p_add;
    assign exec_init_o  = ex_init;
    assign exec_upd_o   = ex_upd;

endmodule

// File: rtl/ptp_addend_acc.sv
module ptp_addend_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             run_en,
    input  logic             fine_en,
    input  logic [ACC_W-1:0] addend,
    output logic             carry_o
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_t;

    acc_t         q, d;
    logic [ACC_W:0] sum;
    logic         active;

    assign active = ref_tick && run_en && fine_en;
    assign sum    = {1'b0, q.acc} + {1'b0, addend};

    always_comb begin
        d = q;
        if (active) begin
            d.acc = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign carry_o = active && sum[ACC_W];

endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
    import ptp_clk_pkg::*;
#(
    parameter int INC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  mode_t             mode,
    input  logic              acc_carry,
    input  logic [INC_W-1:0]  inc,
    input  logic              exec_init,
    input  logic              exec_upd,
    input  logic [DATA_W-1:0] usec,
    input  logic [DATA_W-1:0] uword,
    output logic [DATA_W-1:0] sec_o,
    output logic [DATA_W-1:0] ns_o
);

    localparam int FLD_W = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] sec;
        logic [DATA_W-1:0] ns;
    } time_t;

    time_t           q, d;
    logic [DATA_W:0] limit;
    logic [DATA_W:0] adv_sum;
    logic [DATA_W:0] off_sum;
    logic [DATA_W:0] fld;
    logic            neg;
    logic            step;
    logic [DATA_W-1:0] sec_adj;

    assign limit   = mode.dec ? DEC_LIMIT : BIN_LIMIT;
    assign step    = ref_tick && mode.en && (!mode.fine || acc_carry);
    assign adv_sum = {1'b0, q.ns} + (DATA_W+1)'(inc);
    assign fld     = {2'b00, uword[FLD_W-1:0]};
    assign neg     = uword[DATA_W-1];
    assign off_sum = {1'b0, q.ns} + fld;

    always_comb begin
        d       = q;
        sec_adj = '0;
        if (exec_init) begin
            d.sec = usec;
            d.ns  = {1'b0, uword[FLD_W-1:0]};
        end else if (exec_upd) begin
            if (off_sum >= limit) begin
                d.ns    = DATA_W'(off_sum - limit);
                sec_adj = neg ? '0 : DATA_W'(1);
            end else begin
                d.ns    = off_sum[DATA_W-1:0];
                sec_adj = neg ? '1 : '0;
            end
            d.sec = q.sec + usec + sec_adj;
        end else if (step) begin
            if (adv_sum >= limit) begin
                d.ns  = DATA_W'(adv_sum - limit);
                d.sec = q.sec + DATA_W'(1);
            end else begin
                d.ns  = adv_sum[DATA_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sec_o = q.sec;
    assign ns_o  = q.ns;

endmodule

// File: rtl/ptp_sys_clock.sv
module ptp_sys_clock
    import ptp_clk_pkg::*;
#(
    parameter int INC_W   = 8,
    parameter int SUBNS_W = 8,
    parameter int ACC_W   = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_tick,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [31:0] sec_o,
    output logic [31:0] ns_o
);

    mode_t              mode;
    logic [INC_W-1:0]   inc;
    logic [SUBNS_W-1:0] subns;
    logic [ACC_W-1:0]   add_sh;
    logic [ACC_W-1:0]   add_act;
    logic [DATA_W-1:0]  usec;
    logic [DATA_W-1:0]  uword;
    logic               pend_init;
    logic               pend_upd;
    logic               pend_add;
    logic               exec_init;
    logic               exec_upd;
    logic               acc_carry;
    logic               run_en;
    logic               fine_en;
    logic               dec_en;
    logic [DATA_W-1:0]  ctrl_rd;

    assign run_en  = mode.en;
    assign fine_en = mode.fine;
    assign dec_en  = mode.dec;

    ptp_clk_regs #(
        .INC_W   (INC_W),
        .SUBNS_W (SUBNS_W),
        .ACC_W   (ACC_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_tick     (ref_tick),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .mode_o       (mode),
        .inc_o        (inc),
        .subns_o      (subns),
        .add_shadow_o (add_sh),
        .add_active_o (add_act),
        .usec_o       (usec),
        .uword_o      (uword),
        .pend_init_o  (pend_init),
        .pend_upd_o   (pend_upd),
        .pend_add_o   (pend_add),
        .exec_init_o  (exec_init),
        .exec_upd_o   (exec_upd)
    );

    ptp_addend_acc #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .run_en   (run_en),
        .fine_en  (fine_en),
        .addend   (add_act),
        .carry_o  (acc_carry)
    );

    ptp_time_core #(
        .INC_W (INC_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .mode      (mode),
        .acc_carry (acc_carry),
        .inc       (inc),
        .exec_init (exec_init),
        .exec_upd  (exec_upd),
        .usec      (usec),
        .uword     (uword),
        .sec_o     (sec_o),
        .ns_o      (ns_o)
    );

    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[CB_EN]    = run_en;
        ctrl_rd[CB_FINE]  = fine_en;
        ctrl_rd[CB_INIT]  = pend_init;
        ctrl_rd[CB_UPD]   = pend_upd;
        ctrl_rd[CB_ADDLD] = pend_add;
        ctrl_rd[CB_DEC]   = dec_en;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_CTRL:   bus_rdata = ctrl_rd;
            RA_INCR:   bus_rdata = DATA_W'({subns, inc});
            RA_ADDEND: bus_rdata = DATA_W'(add_sh);
            RA_USEC:   bus_rdata = usec;
            RA_UWORD:  bus_rdata = uword;
            RA_SEC:    bus_rdata = sec_o;
            RA_NSEC:   bus_rdata = ns_o;
            default:   bus_rdata = DATA_W'(add_act);
        endcase
    end

endmodule

// File: rtl/ptp_sys_clock_chk.sv
module ptp_sys_clock_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ref_tick,
    input logic [31:0] sec,
    input logic [31:0] ns,
    input logic        run_en,
    input logic        pend_init,
    input logic        pend_upd,
    input logic        pend_add
);

    // R2: no tick, no movement
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> ($stable(sec) && $stable(ns)));

    // R11: disabled and no command pending, ticks do nothing
    a_r11_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && !run_en && !pend_init && !pend_upd) |=> ($stable(sec) && $stable(ns)));

    // R3: a plain step moves seconds by at most one
    a_r3_sec_single_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && !pend_init && !pend_upd) |=>
        ((sec == $past(sec)) || (sec == $past(sec) + 32'd1)));

    // R10: pending commands survive until a tick
    a_r10_init_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_init && !ref_tick) |=> pend_init);
    a_r10_upd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_upd && !ref_tick) |=> pend_upd);
    a_r10_add_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_add && !ref_tick) |=> pend_add);

    // R6: addend load completes on its tick
    a_r6_addend_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_add && ref_tick) |=> !pend_add);

    // R7: load before offset when both wait
    a_r7_init_first: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_init && pend_upd && ref_tick) |=> (!pend_init && pend_upd));

endmodule

bind ptp_sys_clock ptp_sys_clock_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .sec       (sec_o),
    .ns        (ns_o),
    .run_en    (run_en),
    .pend_init (pend_init),
    .pend_upd  (pend_upd),
    .pend_add  (pend_add)
);

// File: tb/sim_ptp_sys_clock.sv
`timescale 1ns/1ps
module sim_ptp_sys_clock;

    localparam int  CLK_NS = 20;
    localparam longint TWO32 = 64'h1_0000_0000;
    localparam longint DECL  = 1000000000;
    localparam longint BINL  = 64'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [31:0] sec_o;
    logic [31:0] ns_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit tick_on  = 1'b0;
    int tick_div = 1;
    int tick_cnt = 0;

    // reference model state
    longint m_sec = 0, m_ns = 0, m_acc = 0;
    longint m_inc = 0, m_sub = 0, m_ash = 0, m_act = 0, m_usec = 0, m_uw = 0;
    bit m_en = 0, m_fine = 0, m_dec = 0, p_init = 0, p_upd = 0, p_add = 0;

    ptp_sys_clock u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sec_o     (sec_o),
        .ns_o      (ns_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint mread(input int a);
        case (a)
            0: return longint'(m_en) | (longint'(m_fine) << 1) | (longint'(p_init) << 2) |
                      (longint'(p_upd) << 3) | (longint'(p_add) << 5) | (longint'(m_dec) << 9);
            1: return (m_sub << 8) | m_inc;
            2: return m_ash;
            3: return m_usec;
            4: return m_uw;
            5: return m_sec;
            6: return m_ns;
            default: return m_act;
        endcase
    endfunction

    // behavioural reference, updated on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_ns = 0; m_acc = 0; m_inc = 0; m_sub = 0; m_ash = 0; m_act = 0;
            m_usec = 0; m_uw = 0; m_en = 0; m_fine = 0; m_dec = 0;
            p_init = 0; p_upd = 0; p_add = 0;
        end else begin
            bit ei, eu, ea, stp;
            longint lim, t, f;
            ei  = ref_tick && p_init;
            eu  = ref_tick && p_upd && !p_init;
            ea  = ref_tick && p_add;
            stp = 0;
            if (ref_tick && m_en) begin
                if (m_fine) begin
                    t = m_acc + m_act;
                    stp = (t >= TWO32);
                    m_acc = t % TWO32;
                end else begin
                    stp = 1;
                end
            end
            lim = m_dec ? DECL : BINL;
            if (ei) begin
                m_sec = m_usec;
                m_ns  = m_uw % BINL;
            end else if (eu) begin
                f = m_uw % BINL;
                t = m_ns + f;
                m_sec = (m_sec + m_usec) % TWO32;
                if (m_uw >= BINL) begin
                    if (t >= lim) m_ns = t - lim;
                    else begin m_ns = t; m_sec = (m_sec + TWO32 - 1) % TWO32; end
                end else begin
                    if (t >= lim) begin m_ns = t - lim; m_sec = (m_sec + 1) % TWO32; end
                    else m_ns = t;
                end
            end else if (stp) begin
                t = m_ns + m_inc;
                if (t >= lim) begin m_ns = t - lim; m_sec = (m_sec + 1) % TWO32; end
                else m_ns = t;
            end
            if (ea) m_act = m_ash;
            p_init = p_init ? !ei : (bus_we && bus_addr == 0 && bus_wdata[2]);
            p_upd  = p_upd  ? !eu : (bus_we && bus_addr == 0 && bus_wdata[3]);
            p_add  = p_add  ? !ea : (bus_we && bus_addr == 0 && bus_wdata[5]);
            if (bus_we) begin
                case (bus_addr)
                    3'd0: begin m_en = bus_wdata[0]; m_fine = bus_wdata[1]; m_dec = bus_wdata[9]; end
                    3'd1: begin m_inc = bus_wdata[7:0]; m_sub = bus_wdata[15:8]; end
                    3'd2: m_ash = bus_wdata;
                    3'd3: m_usec = bus_wdata;
                    3'd4: m_uw = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // tick generator
    always @(negedge clk) begin
        ref_tick = tick_on && (tick_cnt % tick_div == 0);
        tick_cnt++;
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(sec_o == 32'(m_sec), "R2/R3/R4/R5/R7/R8/R9/R11 seconds", sec_o, m_sec);
            chk(ns_o == 32'(m_ns), "R2/R3/R4/R5/R7/R8/R9/R11 nanoseconds", ns_o, m_ns);
        end
    end

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, input string req);
        @(negedge clk);
        bus_addr = 3'(a);
        #1;
        chk(bus_rdata == 32'(mread(a)), req, bus_rdata, mread(a));
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_up();
    end

    initial begin
        run(4);
        rst_n = 1'b1;
        // R1: everything reads zero after reset
        for (int a = 0; a < 8; a++) begin
            @(negedge clk); bus_addr = 3'(a); #1;
            chk(bus_rdata == 32'd0, "R1 reset value", bus_rdata, 0);
        end
        // R12: register map readback
        wr(1, 32'h0000_0514);
        rd(1, "R12 increment readback");
        wr(3, 32'h1234_5678); rd(3, "R12 seconds word");
        wr(4, 32'h0000_0100); rd(4, "R12 nanoseconds word");
        wr(2, 32'h0BAD_F00D); rd(2, "R12 addend register");
        rd(7, "R12 active addend unchanged before load");
        // R2: coarse decimal counting every tick
        tick_on = 1; tick_div = 1;
        wr(0, 32'h201);
        run(30);
        rd(6, "R2 live nanoseconds");
        // R2: hold between sparse ticks
        tick_div = 3; run(20); tick_div = 1;
        // R7/R3: load near decimal wrap then roll
        tick_on = 0;
        wr(3, 32'd5); wr(4, 32'd999_999_990);
        wr(0, 32'h205);
        @(negedge clk); bus_addr = 3'd0; #1;
        chk(bus_rdata[2] == 1'b1, "R7 load pending bit", bus_rdata[2], 1);
        tick_on = 1; run(6);
        rd(0, "R7 load bit cleared");
        rd(5, "R3 seconds after decimal wrap");
        // R4: binary wrap
        tick_on = 0;
        wr(3, 32'd100); wr(4, 32'h7FFF_FFF0); wr(0, 32'h005);
        tick_on = 1; run(6);
        rd(6, "R4 nanoseconds after binary wrap");
        // R4: seconds wrap to zero
        tick_on = 0;
        wr(3, 32'hFFFF_FFFF); wr(4, 32'h7FFF_FFF8); wr(0, 32'h005);
        tick_on = 1; run(4);
        rd(5, "R4 seconds modulo wrap");
        // R8: positive offset with carry (decimal)
        tick_on = 0;
        wr(3, 32'd10); wr(4, 32'd999_999_000); wr(0, 32'h205);
        tick_on = 1; run(3); tick_on = 0;
        wr(3, 32'd3); wr(4, 32'd2000); wr(0, 32'h209);
        tick_on = 1; run(3);
        rd(5, "R8 seconds after positive offset");
        // R9: subtract with borrow (decimal): minus 2 s 600 ms
        tick_on = 0;
        wr(3, 32'd50); wr(4, 32'd100); wr(0, 32'h205);
        tick_on = 1; run(2); tick_on = 0;
        wr(3, 32'hFFFF_FFFE); wr(4, 32'h8000_0000 | 32'd400_000_000); wr(0, 32'h209);
        tick_on = 1; run(2);
        rd(5, "R9 seconds after borrow");
        // R9: subtract without borrow: minus 1 s 50 ns
        tick_on = 0;
        wr(3, 32'hFFFF_FFFF); wr(4, 32'h8000_0000 | 32'd999_999_950); wr(0, 32'h209);
        tick_on = 1; run(2);
        rd(6, "R9 nanoseconds without borrow");
        // R9: binary subtract of 1000 ns
        tick_on = 0;
        wr(3, 32'd0); wr(4, 32'h8000_0000 | 32'h7FFF_FC18); wr(0, 32'h009);
        tick_on = 1; run(2);
        rd(5, "R9 binary subtract seconds");
        // R10: a pending offset cannot be cancelled
        tick_on = 0;
        wr(3, 32'd7); wr(4, 32'd5); wr(0, 32'h209);
        wr(0, 32'h201);
        @(negedge clk); bus_addr = 3'd0; #1;
        chk(bus_rdata[3] == 1'b1, "R10 pending bit survives write of 0", bus_rdata[3], 1);
        tick_on = 1; run(3);
        rd(5, "R10 offset still applied");
        // R7: load and offset queued together
        tick_on = 0;
        wr(3, 32'd20); wr(4, 32'd30); wr(0, 32'h20D);
        tick_on = 1; run(4);
        rd(5, "R7 load then offset");
        // R6/R5: addend load and fine mode
        tick_on = 0;
        wr(2, 32'h4000_0000); wr(0, 32'h223);
        rd(0, "R6 load bit pending");
        rd(7, "R6 active addend not yet loaded");
        tick_on = 1; run(20);
        rd(7, "R6 active addend loaded");
        rd(6, "R5 fine-mode nanoseconds");
        tick_on = 0;
        wr(2, 32'hC000_0001); wr(0, 32'h223);
        tick_on = 1; tick_div = 2; run(30); tick_div = 1;
        rd(6, "R5 fine-mode with large addend");
        // R11: disabled counter, ticks ignored, commands still run
        wr(0, 32'h200);
        run(10);
        rd(6, "R11 frozen nanoseconds");
        wr(3, 32'd77); wr(4, 32'd88); wr(0, 32'h204);
        run(3);
        rd(5, "R11 load while disabled");
        wr(0, 32'h203);
        run(10);
        rd(6, "R11 accumulator held while off");
        run(2);
        finish_up();
    end

endmodule